// File: doc/BRIEF.md
# Programmable-Format Serial Character Receiver

This block recovers characters from an asynchronous serial line. The line is sampled on a clock-enable pulse that runs at sixteen times the bit rate. A five-bit format word picks the number of data bits (5 to 8), whether a parity bit follows the data, whether that parity is odd or even, and the stop length. The format word is the same one the matching transmitter uses.

Each character that completes produces a one-cycle strobe. The received byte and two error flags are shown with that strobe. Characters shorter than eight bits come out zero-extended.

The output is a valid-only stream with no ready input. A serial line cannot be stalled, so there is no back-pressure: the consumer must take the byte in the cycle the strobe is high. After that cycle the byte stays on `rx_data` until the next character completes, but it is only guaranteed valid during the strobe.

Top module: `serial_char_rx`

## Requirements
- R1: Data bits are taken least significant first, directly after the start bit. The count is set by `fmt_cfg[1:0]`: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8.
- R2: The line goes through a two-flop synchronizer. A low level seen on a tick is accepted as a start bit only if the line is still low eight ticks later. A pulse that has gone high again by then produces no character.
- R3: When `fmt_cfg[3]` is 1, one parity bit follows the data and is checked. With `fmt_cfg[4]` at 0, the data bits plus the parity bit must hold an odd number of ones; with `fmt_cfg[4]` at 1, an even number. A mismatch raises `parity_err`. When `fmt_cfg[3]` is 0, no parity bit is expected and `parity_err` stays 0.
- R4: Bit positions at or above the configured word length read as 0 in `rx_data`.
- R5: The first stop bit is sampled at its centre. If it is low, `frame_err` is raised and the data bits are still delivered.
- R6: `rx_valid` is high for exactly one clock per character. `rx_data`, `parity_err` and `frame_err` are valid in that same clock. Both flags are 0 in every other clock.
- R7: After reset, and after every character, the receiver waits for the line to be high before it looks for a start bit. A line held low for a long time yields only one character.
- R8: `fmt_cfg[2]` selects the stop length. It has no effect on reception: only the first stop bit is checked, so a new start bit that follows a single stop bit is received whatever `fmt_cfg[2]` is.
- R9: The format is captured when the start bit is confirmed. A change to `fmt_cfg` during a character does not affect that character.
- R10: After reset, `rx_valid`, `rx_data`, `parity_err` and `frame_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | 1 | Serial input, asynchronous, idles high |
| tick16 | input | 1 | Sampling enable, one clock wide, at 16 times the bit rate |
| fmt_cfg | input | 5 | [1:0] word length, [2] stop length, [3] parity enable, [4] even parity |
| rx_data | output | 8 | Received character, zero-extended |
| rx_valid | output | 1 | One-clock strobe for a completed character |
| parity_err | output | 1 | Parity mismatch, valid with `rx_valid` |
| frame_err | output | 1 | First stop bit sampled low, valid with `rx_valid` |

## Verification
The assertions assume three things about the inputs:
- `tick16` is a one-clock pulse that comes at a steady spacing.
- The serial line changes only at bit boundaries.
- Each bit is held for sixteen ticks, so every centre sample sees a settled level.

The stimulus keeps to these rules. It spaces ticks four clocks apart, drives the line away from the active edge, and holds each bit for sixty-four clocks. Deliberate glitches are kept shorter than half a bit, so they fall entirely within the start-validation window.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    S_ARM,
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP
  } srx_state_e;

  typedef struct packed {
    logic       even;
    logic       par_en;
    logic [1:0] wsel;
  } srx_fmt_t;

  function automatic logic [3:0] word_bits(input logic [1:0] sel);
    return 4'd5 + {2'b00, sel};
  endfunction
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe <= '1;
        else        pipe <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], d};
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/srx_deser.sv
module srx_deser #(
  parameter int W  = 8,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr,
  input  logic [IW-1:0] idx,
  input  logic          bit_in,
  output logic [W-1:0]  data
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   data <= '0;
    else if (clr) data <= '0;
    else if (wr)  data[idx] <= bit_in;

  // zero-extension relies on unwritten positions keeping their cleared value
  assert_hold_between_writes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !wr) |=> $stable(data))
    else $error("deser changed without a write");
endmodule

// File: rtl/srx_parity.sv
module srx_parity #(
  parameter int W = 8
) (
  input  logic [W-1:0] data,
  input  logic         pbit,
  input  logic         even,
  output logic         err
);
  // odd: total ones must be odd; even: total ones must be even
  assign err = (^data) ^ pbit ^ ~even;
endmodule

// File: rtl/serial_char_rx.sv
module serial_char_rx
  import srx_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int SYNC_LEN  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_line,
  input  logic                tick16,
  input  logic [4:0]          fmt_cfg,
  output logic [DATA_W-1:0]   rx_data,
  output logic                rx_valid,
  output logic                parity_err,
  output logic                frame_err
);
  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(DATA_W);
  localparam logic [CW-1:0] MID_C  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST_C = CW'(OVS - 1);

  srx_state_e        state;
  logic              rx_s;
  logic [CW-1:0]     tcnt;
  logic [IW-1:0]     bidx;
  srx_fmt_t          fmt_q;
  logic              perr_q;
  logic [DATA_W-1:0] shreg;
  logic              par_bad;
  logic              start_ok;
  logic              bit_pt;
  logic              wr_bit;
  logic [IW-1:0]     last_idx;
  logic              unused_stop_sel;

  assign unused_stop_sel = fmt_cfg[2];

  srx_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_line), .q(rx_s)
  );

  assign start_ok = (state == S_START) && tick16 && (tcnt == MID_C) && !rx_s;
  assign bit_pt   = tick16 && (tcnt == LAST_C);
  assign wr_bit   = (state == S_DATA) && bit_pt;
  assign last_idx = IW'(word_bits(fmt_q.wsel) - 4'd1);

  srx_deser #(.W(DATA_W)) u_deser (
    .clk(clk), .rst_n(rst_n), .clr(start_ok), .wr(wr_bit),
    .idx(bidx), .bit_in(rx_s), .data(shreg)
  );

  srx_parity #(.W(DATA_W)) u_par (
    .data(shreg), .pbit(rx_s), .even(fmt_q.even), .err(par_bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_ARM;
      tcnt       <= '0;
      bidx       <= '0;
      fmt_q      <= '0;
      perr_q     <= 1'b0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      parity_err <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      rx_valid   <= 1'b0;
      parity_err <= 1'b0;
      frame_err  <= 1'b0;
      case (state)
        S_ARM:  if (rx_s) state <= S_IDLE;
        S_IDLE: if (tick16 && !rx_s) begin
          state <= S_START;
          tcnt  <= '0;
        end
        S_START: if (tick16) begin
          if (tcnt == MID_C) begin
            tcnt <= '0;
            if (!rx_s) begin
              state  <= S_DATA;
              bidx   <= '0;
              perr_q <= 1'b0;
              fmt_q  <= '{even: fmt_cfg[4], par_en: fmt_cfg[3], wsel: fmt_cfg[1:0]};
            end else begin
              state <= S_IDLE;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        S_DATA: if (tick16) begin
          tcnt <= tcnt + 1'b1;
          if (bit_pt) begin
            tcnt <= '0;
            if (bidx == last_idx) state <= fmt_q.par_en ? S_PAR : S_STOP;
            else                  bidx  <= bidx + 1'b1;
          end
        end
        S_PAR: if (tick16) begin
          tcnt <= tcnt + 1'b1;
          if (bit_pt) begin
            tcnt   <= '0;
            perr_q <= par_bad;
            state  <= S_STOP;
          end
        end
        S_STOP: if (tick16) begin
          tcnt <= tcnt + 1'b1;
          if (bit_pt) begin
            tcnt       <= '0;
            rx_data    <= shreg;
            rx_valid   <= 1'b1;
            parity_err <= perr_q & fmt_q.par_en;
            frame_err  <= ~rx_s;
            state      <= S_ARM;
          end
        end
        default: state <= S_ARM;
      endcase
    end
  end

  assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid)
    else $error("strobe longer than one clock");

  assert_flags_with_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (parity_err || frame_err) |-> rx_valid)
    else $error("error flag outside strobe");

  assert_zero_extend_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ((rx_data >> word_bits(fmt_q.wsel)) == '0))
    else $error("bits above word length not zero");

  assert_glitch_to_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_START && tick16 && tcnt == MID_C && rx_s) |=> (state == S_IDLE))
    else $error("glitch not rejected");

  assert_parity_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err |-> fmt_q.par_en)
    else $error("parity error without parity enabled");

  assert_arm_waits_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ARM) |=> (state == S_ARM || state == S_IDLE))
    else $error("start search before line high");
endmodule

// File: tb/serial_char_rx_test.sv
module serial_char_rx_test;
  localparam int BITCLK = 64;

  typedef struct packed {
    logic [4:0] f;
    logic [7:0] d;
    logic       bp;
    logic       bs;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [0:NV-1] = '{
    '{5'b00000, 8'hA5, 1'b0, 1'b0},
    '{5'b00001, 8'h3C, 1'b0, 1'b0},
    '{5'b00010, 8'hFF, 1'b0, 1'b0},
    '{5'b00011, 8'h5A, 1'b0, 1'b0},
    '{5'b01011, 8'h96, 1'b0, 1'b0},
    '{5'b11011, 8'h96, 1'b1, 1'b0},
    '{5'b01000, 8'h1F, 1'b1, 1'b0},
    '{5'b11001, 8'h2A, 1'b0, 1'b0},
    '{5'b00111, 8'hC3, 1'b0, 1'b1},
    '{5'b11110, 8'h81, 1'b1, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       tick = 1'b0;
  logic [4:0] fmt = 5'b0;
  logic [7:0] rx_data;
  logic       rx_valid, parity_err, frame_err;

  int nchk = 0, nfail = 0;
  int strobes = 0, stray = 0;
  logic [7:0] cap_d [0:7];
  logic       cap_p [0:7];
  logic       cap_f [0:7];

  serial_char_rx uut (
    .clk(clk), .rst_n(rst_n), .rx_line(rxd), .tick16(tick), .fmt_cfg(fmt),
    .rx_data(rx_data), .rx_valid(rx_valid), .parity_err(parity_err), .frame_err(frame_err)
  );

  always #4 clk = ~clk;

  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      tick = (c == 3);
      c = (c + 1) % 4;
    end
  end

  initial forever begin
    @(negedge clk);
    if (rst_n && rx_valid) begin
      if (strobes < 8) begin
        cap_d[strobes] = rx_data;
        cap_p[strobes] = parity_err;
        cap_f[strobes] = frame_err;
      end
      strobes++;
    end else if (rst_n && (parity_err || frame_err)) begin
      stray++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mask_of(input logic [4:0] f);
    return 8'hFF >> (2'd3 - f[1:0]);
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk);
    rxd = b;
    repeat (BITCLK - 1) @(negedge clk);
  endtask

  task automatic send_frame(input logic [4:0] f, input logic [7:0] d,
                            input logic bad_par, input logic stop_val);
    int n = 5 + int'(f[1:0]);
    logic p;
    send_bit(1'b0);
    for (int i = 0; i < n; i++) send_bit(d[i]);
    if (f[3]) begin
      p = (^(d & mask_of(f))) ^ ~f[4];
      send_bit(p ^ bad_par);
    end
    send_bit(stop_val);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 valid", rx_valid, 0);
    check("R10 data", rx_data, 0);
    check("R10 perr", parity_err, 0);
    check("R10 ferr", frame_err, 0);
    repeat (BITCLK) @(negedge clk);

    // table walk: R1 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      fmt = v.f;
      strobes = 0;
      send_frame(v.f, v.d, v.bp, ~v.bs);
      send_bit(1'b1);
      send_bit(1'b1);
      check("R6 one strobe", strobes, 1);
      check("R1/R4 data", cap_d[0], v.d & mask_of(v.f));
      check("R3 parity flag", cap_p[0], v.f[3] & v.bp);
      check("R5 framing flag", cap_f[0], v.bs);
    end

    // R2 glitches shorter than half a bit
    fmt = 5'b00011;
    strobes = 0;
    @(negedge clk); rxd = 1'b0;
    repeat (12) @(negedge clk); rxd = 1'b1;
    repeat (3 * BITCLK) @(negedge clk);
    @(negedge clk); rxd = 1'b0;
    repeat (24) @(negedge clk); rxd = 1'b1;
    repeat (3 * BITCLK) @(negedge clk);
    check("R2 glitch ignored", strobes, 0);

    // R7 line held low: one character only, then recovery
    strobes = 0;
    send_frame(5'b00011, 8'h00, 1'b0, 1'b0);
    repeat (30 * BITCLK) @(negedge clk);
    send_bit(1'b1);
    send_bit(1'b1);
    check("R7 single strobe on held low", strobes, 1);
    check("R7/R5 framing on break", cap_f[0], 1);
    send_frame(5'b00011, 8'h3E, 1'b0, 1'b1);
    send_bit(1'b1);
    check("R7 recovered strobes", strobes, 2);
    check("R7 recovered data", cap_d[1], 8'h3E);

    // R8 back-to-back with one stop bit while two are selected
    fmt = 5'b00111;
    strobes = 0;
    send_frame(5'b00111, 8'h12, 1'b0, 1'b1);
    send_frame(5'b00111, 8'h34, 1'b0, 1'b1);
    send_bit(1'b1);
    check("R8 two strobes", strobes, 2);
    check("R8 first data", cap_d[0], 8'h12);
    check("R8 second data", cap_d[1], 8'h34);
    check("R8 second no frame err", cap_f[1], 0);

    // R9 format change mid-character
    fmt = 5'b00011;
    strobes = 0;
    fork
      send_frame(5'b00011, 8'hB6, 1'b0, 1'b1);
      begin
        repeat (3 * BITCLK) @(negedge clk);
        fmt = 5'b11000;
      end
    join
    send_bit(1'b1);
    check("R9 strobes", strobes, 1);
    check("R9 data uses latched format", cap_d[0], 8'hB6);
    check("R9 no parity err", cap_p[0], 0);

    check("R6 no stray flags", stray, 0);
    finish_run();
  end
endmodule